// File: doc/BRIEF.md
# Pipelined Memory Bus Arbiter

This block runs the memory bus protocol on its own, apart from the processor pipeline. Three on-chip clients compete for the bus: instruction prefetch, page-table walks and data accesses. The block picks one winner per cycle by fixed priority and issues that client's request on the bus. Up to four requests can be in flight at once. Responses are routed back to their clients in the order the requests were issued. An external bus master can ask for the bus. When it does, new on-chip issue stops, the outstanding requests drain, and the bus is then handed over.

Two configuration inputs set the timing. One spreads accesses over one, two or four interleaved banks, chosen by the low address bits. The other is a 4-bit access latency: the number of cycles from issue to data return, which is also how long a bank stays busy. A slow single bank and a fast four-way interleaved system are driven by the same logic. Each client holds its request and address steady until it sees its grant pulse. The configuration must stay constant while any request is outstanding.

Top module: `membus_arbiter`

## Requirements
- R1: After a synchronous reset, all of `req_grant`, `bus_valid`, `ext_grant` and `rsp_valid` are low.
- R2: Among eligible requesters, data (bit 2) wins over walk (bit 1), and walk wins over prefetch (bit 0). A requester's address is `req_addr[i*AW +: AW]`.
- R3: An issue lasts exactly one cycle. In that cycle `bus_valid` is high, `req_grant` is one-hot for the winner, and `bus_addr` carries that requester's address. In every other cycle `req_grant` is zero.
- R4: The winner gets a one-cycle pulse on its bit of `rsp_valid` exactly L cycles after its `bus_valid` cycle. L is `cfg_lat`, and a value of 0 counts as 1.
- R5: Responses come back in issue order.
- R6: At most four requests are outstanding, counting from issue up to the response. While four are outstanding, no issue is made. The earliest new issue comes one cycle after the response that frees a slot.
- R7: `bus_bank` gives the bank of the issued address. With `cfg_ileave`=0 the bank is always 0. With 1 the bank is `addr[0]`. With 2 or 3 the bank is `addr[1:0]`.
- R8: Two issues to the same bank are at least L cycles apart.
- R9: While `ext_req` is high, no new on-chip request is issued. `ext_grant` rises in the cycle after the outstanding count reaches zero. It is only high while nothing is outstanding and no issue is made. It falls one cycle after `ext_req` falls. The first on-chip issue can then follow one cycle later.
- R10: A requester granted in one cycle is ignored in the next. A client that keeps requesting alone is therefore issued at most every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ileave | input | 2 | Interleave mode: 0 = one bank, 1 = two, 2/3 = four |
| cfg_lat | input | 4 | Access latency in cycles (0 counts as 1) |
| req_valid | input | 3 | Request per client: bit 0 prefetch, bit 1 walk, bit 2 data |
| req_addr | input | 96 | Client addresses, 32 bits each, client i at bits i*32 upward |
| ext_req | input | 1 | External master asks for the bus |
| req_grant | output | 3 | One-hot grant pulse, aligned with bus_valid |
| bus_valid | output | 1 | Request issued on the bus this cycle |
| bus_addr | output | 32 | Issued address |
| bus_bank | output | 2 | Bank of the issued address |
| ext_grant | output | 1 | Bus handed to the external master |
| rsp_valid | output | 3 | One-hot return pulse to the issuing client |

## Verification
The state hardest to reach from the ports is a full return queue whose head frees its slot in the same cycle that a blocked bank becomes free again. Only in that state does the four-slot limit, and not the bank timer, decide when the next issue happens. A directed sequence reaches it. Three clients issue to four distinct banks with a latency of eight. A fifth request then targets the first bank, so the test can check that this issue lands one cycle after the first return and not at the bank's release. Random phases sweep every interleave mode and many latencies, with occasional external bus requests. Each issue and each return is checked against a queue model kept in the bench.

// File: rtl/membus_pkg.sv
package membus_pkg;
  // Interleave selection codes seen on cfg_ileave
  typedef enum logic [1:0] {
    ILV_ONE  = 2'd0,
    ILV_TWO  = 2'd1,
    ILV_FOUR = 2'd2,
    ILV_MAX  = 2'd3
  } ilv_mode_e;

  // Requester positions, higher index means higher priority
  localparam int unsigned CLI_PREFETCH = 0;
  localparam int unsigned CLI_WALK     = 1;
  localparam int unsigned CLI_DATA     = 2;

  // A programmed latency of zero behaves as one cycle
  function automatic logic [3:0] lat_floor(input logic [3:0] lat);
    return (lat == 4'd0) ? 4'd1 : lat;
  endfunction
endpackage

// File: rtl/mb_arbiter.sv
module mb_arbiter #(
  parameter int NREQ  = 3,
  parameter int AW    = 32,
  parameter int NBANK = 4,
  parameter int BKW   = 2
) (
  input  logic [NREQ-1:0]    req_valid,
  input  logic [NREQ*AW-1:0] req_addr,
  input  logic [NREQ-1:0]    just_granted,
  input  logic [1:0]         ilv_mode,
  input  logic [NBANK-1:0]   bank_free,
  input  logic               slot_ok,
  input  logic               hold,
  output logic [NREQ-1:0]    win,
  output logic               win_any,
  output logic [AW-1:0]      win_addr,
  output logic [BKW-1:0]     win_bank
);
  logic [BKW-1:0]  bmask;
  logic [BKW-1:0]  rbank [NREQ];
  logic [NREQ-1:0] elig;

  // Bank mask grows with the interleave mode, clamped to the banks built
  always_comb begin
    int sh;
    sh = (int'(ilv_mode) > BKW) ? BKW : int'(ilv_mode);
    bmask = BKW'((1 << sh) - 1);
  end

  for (genvar i = 0; i < NREQ; i++) begin : g_req
    assign rbank[i] = req_addr[i*AW +: BKW] & bmask;
    assign elig[i]  = req_valid[i] && !just_granted[i] && bank_free[rbank[i]]
                      && slot_ok && !hold;
  end

  // Fixed priority: a later (higher) index overrides an earlier one
  always_comb begin
    win      = '0;
    win_addr = '0;
    win_bank = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (elig[i]) begin
        win      = '0;
        win[i]   = 1'b1;
        win_addr = req_addr[i*AW +: AW];
        win_bank = rbank[i];
      end
    end
    win_any = |elig;
  end
endmodule

// File: rtl/mb_bank_timers.sv
module mb_bank_timers #(
  parameter int NBANK = 4,
  parameter int BKW   = 2,
  parameter int LATW  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue,
  input  logic [BKW-1:0]  issue_bank,
  input  logic [LATW-1:0] lat_eff,
  output logic [NBANK-1:0] bank_free
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [LATW-1:0] tmr;

    always_ff @(posedge clk) begin
      if (rst) begin
        tmr <= '0;
      end else if (issue && issue_bank == BKW'(b)) begin
        tmr <= lat_eff;
      end else if (tmr != '0) begin
        tmr <= tmr - LATW'(1);
      end
    end

    // Free when the access time ends at this edge
    assign bank_free[b] = (tmr <= LATW'(1));

    // R8: the arbiter never starts a bank whose access time is still running
    assert_bank_idle_R8: assert property (@(posedge clk) disable iff (rst)
      (issue && issue_bank == BKW'(b)) |-> (tmr <= LATW'(1)));
  end
endmodule

// File: rtl/mb_ret_fifo.sv
module mb_ret_fifo #(
  parameter int DEPTH = 4,
  parameter int IDW   = 2,
  parameter int LATW  = 4,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [IDW-1:0]  push_id,
  input  logic [LATW-1:0] lat_eff,
  output logic            pop,
  output logic [IDW-1:0]  pop_id,
  output logic [CNTW-1:0] occ,
  output logic            full
);
  logic [IDW-1:0]  id_mem [DEPTH];
  logic [LATW-1:0] tmr    [DEPTH];
  logic [PTRW-1:0] wr_ptr, rd_ptr;

  // Requester IDs kept in a plain write-port array
  always_ff @(posedge clk) begin
    if (push) id_mem[wr_ptr] <= push_id;
  end
  assign pop_id = id_mem[rd_ptr];

  // Per-slot countdown to the data return
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        tmr[s] <= '0;
      end else if (push && wr_ptr == PTRW'(s)) begin
        tmr[s] <= lat_eff;
      end else if (tmr[s] != '0) begin
        tmr[s] <= tmr[s] - LATW'(1);
      end
    end
  end

  assign full = (occ == CNTW'(DEPTH));
  assign pop  = (occ != '0) && (tmr[rd_ptr] == LATW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTRW'(DEPTH - 1)) ? '0 : wr_ptr + PTRW'(1);
      if (pop)  rd_ptr <= (rd_ptr == PTRW'(DEPTH - 1)) ? '0 : rd_ptr + PTRW'(1);
      case ({push, pop})
        2'b10:   occ <= occ + CNTW'(1);
        2'b01:   occ <= occ - CNTW'(1);
        default: occ <= occ;
      endcase
    end
  end

  // R6: no request is accepted into a full tracker
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R4: the latency loaded into a slot is never zero
  assert_lat_floor_R4: assert property (@(posedge clk) disable iff (rst)
    push |-> (lat_eff != '0));
endmodule

// File: rtl/membus_arbiter.sv
module membus_arbiter
  import membus_pkg::*;
#(
  parameter int NREQ  = 3,
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  parameter int NBANK = 4,
  parameter int LATW  = 4,
  localparam int BKW  = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int IDW  = (NREQ > 1) ? $clog2(NREQ) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_ileave,
  input  logic [LATW-1:0]   cfg_lat,
  input  logic [NREQ-1:0]   req_valid,
  input  logic [NREQ*AW-1:0] req_addr,
  input  logic              ext_req,
  output logic [NREQ-1:0]   req_grant,
  output logic              bus_valid,
  output logic [AW-1:0]     bus_addr,
  output logic [BKW-1:0]    bus_bank,
  output logic              ext_grant,
  output logic [NREQ-1:0]   rsp_valid
);
  logic [LATW-1:0]  lat_eff;
  logic [NBANK-1:0] bank_free;
  logic [NREQ-1:0]  win;
  logic             win_any;
  logic [AW-1:0]    win_addr;
  logic [BKW-1:0]   win_bank;
  logic             pop, full;
  logic [IDW-1:0]   pop_id;
  logic [IDW-1:0]   win_id;
  logic [CNTW-1:0]  occ;

  assign lat_eff = (cfg_lat == '0) ? LATW'(1) : cfg_lat;

  always_comb begin
    win_id = '0;
    for (int i = 0; i < NREQ; i++) if (win[i]) win_id = IDW'(i);
  end

  mb_arbiter #(.NREQ(NREQ), .AW(AW), .NBANK(NBANK), .BKW(BKW)) u_arb (
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .just_granted(req_grant),
    .ilv_mode    (cfg_ileave),
    .bank_free   (bank_free),
    .slot_ok     (!full),
    .hold        (ext_req || ext_grant),
    .win         (win),
    .win_any     (win_any),
    .win_addr    (win_addr),
    .win_bank    (win_bank)
  );

  mb_bank_timers #(.NBANK(NBANK), .BKW(BKW), .LATW(LATW)) u_banks (
    .clk       (clk),
    .rst       (rst),
    .issue     (win_any),
    .issue_bank(win_bank),
    .lat_eff   (lat_eff),
    .bank_free (bank_free)
  );

  mb_ret_fifo #(.DEPTH(DEPTH), .IDW(IDW), .LATW(LATW)) u_ret (
    .clk    (clk),
    .rst    (rst),
    .push   (win_any),
    .push_id(win_id),
    .lat_eff(lat_eff),
    .pop    (pop),
    .pop_id (pop_id),
    .occ    (occ),
    .full   (full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_grant <= '0;
      bus_valid <= 1'b0;
      bus_addr  <= '0;
      bus_bank  <= '0;
      ext_grant <= 1'b0;
      rsp_valid <= '0;
    end else begin
      req_grant <= win;
      bus_valid <= win_any;
      if (win_any) begin
        bus_addr <= win_addr;
        bus_bank <= win_bank;
      end
      ext_grant <= ext_req && (ext_grant || occ == '0);
      rsp_valid <= '0;
      if (pop) rsp_valid[pop_id] <= 1'b1;
    end
  end

  // R3: at most one client granted per cycle
  assert_onehot_grant_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_grant));
  // R9: external ownership only over an empty, quiet bus
  assert_ext_excl_R9: assert property (@(posedge clk) disable iff (rst)
    ext_grant |-> (occ == '0 && !bus_valid));
  // R9: ownership is released one cycle after the request drops
  assert_ext_release_R9: assert property (@(posedge clk) disable iff (rst)
    !ext_req |=> !ext_grant);
  // R10: a client is never granted in two consecutive cycles
  assert_no_regrant_R10: assert property (@(posedge clk) disable iff (rst)
    (|req_grant) |=> ((req_grant & $past(req_grant)) == '0));
  // R5: returns go to exactly one client
  assert_rsp_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_valid));
endmodule

// File: tb/membus_arbiter_test.sv
module membus_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  cfg_ileave = 2'd2;
  logic [3:0]  cfg_lat = 4'd3;
  logic [2:0]  req_valid = '0;
  logic [95:0] req_addr = '0;
  logic        ext_req = 1'b0;
  logic [2:0]  req_grant;
  logic        bus_valid;
  logic [31:0] bus_addr;
  logic [1:0]  bus_bank;
  logic        ext_grant;
  logic [2:0]  rsp_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  membus_arbiter uut (
    .clk(clk), .rst(rst), .cfg_ileave(cfg_ileave), .cfg_lat(cfg_lat),
    .req_valid(req_valid), .req_addr(req_addr), .ext_req(ext_req),
    .req_grant(req_grant), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_bank(bus_bank), .ext_grant(ext_grant), .rsp_valid(rsp_valid)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, outstanding = 0;
  logic [31:0] q0[$], q1[$], q2[$];
  int iss_r[$], iss_t[$], iss_b[$], rsp_t[$], pend_r[$], pend_t[$];
  int last_bank_t [4];
  logic [2:0] last_grant = '0;
  bit ext_want = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int effl();
    return (cfg_lat == 4'd0) ? 1 : int'(cfg_lat);
  endfunction

  function automatic int bank_of(input logic [31:0] a, input logic [1:0] m);
    if (m == 2'd0) return 0;
    if (m == 2'd1) return int'(a[0]);
    return int'(a[1:0]);
  endfunction

  task automatic q_push(input int r, input logic [31:0] a);
    if (r == 0) q0.push_back(a); else if (r == 1) q1.push_back(a); else q2.push_back(a);
  endtask
  function automatic int q_size(input int r);
    return (r == 0) ? q0.size() : (r == 1) ? q1.size() : q2.size();
  endfunction
  task automatic q_pop(input int r);
    if (r == 0) void'(q0.pop_front()); else if (r == 1) void'(q1.pop_front());
    else void'(q2.pop_front());
  endtask
  function automatic logic [31:0] q_front(input int r);
    return (r == 0) ? q0[0] : (r == 1) ? q1[0] : q2[0];
  endfunction

  task automatic clear_banks();
    for (int b = 0; b < 4; b++) last_bank_t[b] = -100000;
  endtask

  task automatic monitor();
    if (bus_valid) begin
      int r, b;
      r = 0;
      for (int i = 0; i < 3; i++) if (req_grant[i]) r = i;
      b = bank_of(bus_addr, cfg_ileave);
      chk($countones(req_grant) == 1, "R3 onehot grant", req_grant, 1);
      chk(req_valid[r] && bus_addr == req_addr[r*AW +: AW], "R3 issued address",
          bus_addr, req_addr[r*AW +: AW]);
      chk(int'(bus_bank) == b, "R7 bank select", bus_bank, b);
      chk(cyc - last_bank_t[b] >= effl(), "R8 bank spacing", cyc - last_bank_t[b], effl());
      chk(outstanding < 4, "R6 outstanding limit", outstanding, 3);
      chk(!ext_grant && !ext_req, "R9 issue during external request", ext_req, 0);
      chk((req_grant & last_grant) == 0, "R10 back-to-back grant", req_grant, 0);
      iss_r.push_back(r); iss_t.push_back(cyc); iss_b.push_back(int'(bus_bank));
      pend_r.push_back(r); pend_t.push_back(cyc);
      last_bank_t[b] = cyc;
      outstanding++;
    end else if (req_grant != 0) begin
      chk(0, "R3 grant without issue", req_grant, 0);
    end
    if (rsp_valid != 0) begin
      if (pend_r.size() == 0) begin
        chk(0, "R5 spurious return", rsp_valid, 0);
      end else begin
        chk(rsp_valid == (3'b001 << pend_r[0]), "R5 return order", rsp_valid, 3'b001 << pend_r[0]);
        chk(cyc == pend_t[0] + effl(), "R4 return latency", cyc - pend_t[0], effl());
        void'(pend_r.pop_front()); void'(pend_t.pop_front());
        outstanding--;
        rsp_t.push_back(cyc);
      end
    end else if (pend_r.size() != 0 && cyc >= pend_t[0] + effl()) begin
      chk(0, "R4 missing return", cyc - pend_t[0], effl());
      void'(pend_r.pop_front()); void'(pend_t.pop_front());
      outstanding--;
    end
    if (ext_grant) chk(outstanding == 0 && !bus_valid, "R9 external ownership", outstanding, 0);
    last_grant = req_grant;
  endtask

  task automatic drive();
    logic [2:0]  v;
    logic [95:0] a;
    v = '0; a = '0;
    for (int r = 0; r < 3; r++) begin
      if (req_grant[r] && q_size(r) > 0) q_pop(r);
      if (q_size(r) > 0) begin
        v[r] = 1'b1;
        a[r*AW +: AW] = q_front(r);
      end
    end
    req_valid = v;
    req_addr  = a;
    ext_req   = ext_want;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    monitor();
    drive();
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    ext_want = 0;
    while ((q0.size() + q1.size() + q2.size() + outstanding) != 0 || ext_grant || ext_req) begin
      if (n >= 400) break;
      step();
      n++;
    end
    chk(n < 400, "drain watchdog", n, 400);
    repeat (2) step();
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [3:0] l);
    cfg_ileave = m;
    cfg_lat = l;
    clear_banks();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int ib, rb, seed_init, hold_cnt;
    seed_init = $urandom(32'd20240611);
    clear_banks();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_grant == 0 && !bus_valid && !ext_grant && rsp_valid == 0, "R1 reset state",
        {req_grant, bus_valid, ext_grant, rsp_valid}, 0);

    // R2 priority and R4/R5 timing, four banks, latency 3
    set_cfg(2'd2, 4'd3);
    ib = iss_t.size(); rb = rsp_t.size();
    q_push(2, 32'h10); q_push(1, 32'h21); q_push(0, 32'h32);
    wait_idle();
    chk(iss_r[ib] == 2 && iss_r[ib+1] == 1 && iss_r[ib+2] == 0, "R2 priority order",
        iss_r[ib]*100 + iss_r[ib+1]*10 + iss_r[ib+2], 210);
    chk(iss_t[ib+2] - iss_t[ib] == 2, "R2 back-to-back issue", iss_t[ib+2] - iss_t[ib], 2);
    chk(rsp_t[rb+2] - iss_t[ib+2] == 3, "R4 latency three", rsp_t[rb+2] - iss_t[ib+2], 3);

    // R8 single bank, latency 5
    set_cfg(2'd0, 4'd5);
    ib = iss_t.size();
    q_push(2, 32'h100); q_push(1, 32'h205);
    wait_idle();
    chk(iss_t[ib+1] - iss_t[ib] == 5, "R8 bank busy wait", iss_t[ib+1] - iss_t[ib], 5);

    // R6 full tracker against bank release, four banks, latency 8
    set_cfg(2'd2, 4'd8);
    ib = iss_t.size(); rb = rsp_t.size();
    q_push(2, 32'h0); q_push(2, 32'h3); q_push(1, 32'h1); q_push(1, 32'h4); q_push(0, 32'h2);
    wait_idle();
    chk(iss_t[ib+4] - iss_t[ib] == 9, "R6 fifth issue time", iss_t[ib+4] - iss_t[ib], 9);
    chk(iss_t[ib+4] - rsp_t[rb] == 1, "R6 slot freed by return", iss_t[ib+4] - rsp_t[rb], 1);
    chk(iss_r[ib+2] == 2 && iss_r[ib+3] == 0, "R2 data before prefetch",
        iss_r[ib+2]*10 + iss_r[ib+3], 20);

    // R9 external master handover
    set_cfg(2'd2, 4'd6);
    ib = iss_t.size(); rb = rsp_t.size();
    q_push(2, 32'h0); q_push(1, 32'h1);
    step();
    step();
    ext_want = 1;
    q_push(0, 32'h2);
    begin
      int n, rise, fall;
      n = 0;
      while (!ext_grant && n < 60) begin step(); n++; end
      rise = cyc;
      chk(rsp_t.size() == rb + 2 && rise == rsp_t[rsp_t.size()-1] + 1, "R9 grant after drain",
          rise, rsp_t[rsp_t.size()-1] + 1);
      repeat (3) step();
      chk(iss_t.size() == ib + 2, "R9 no issue while owned", iss_t.size() - ib, 2);
      ext_want = 0;
      n = 0;
      while (ext_grant && n < 10) begin step(); n++; end
      fall = cyc;
      chk(n == 2, "R9 release delay", n, 2);
      n = 0;
      while (!bus_valid && n < 10) begin step(); n++; end
      chk(cyc == fall + 1, "R9 first issue after release", cyc - fall, 1);
    end
    wait_idle();

    // R4 zero latency and R7 two-bank mapping
    set_cfg(2'd1, 4'd0);
    ib = iss_t.size(); rb = rsp_t.size();
    q_push(2, 32'h6); q_push(1, 32'h5);
    wait_idle();
    chk(rsp_t[rb] - iss_t[ib] == 1, "R4 zero latency as one", rsp_t[rb] - iss_t[ib], 1);
    chk(iss_b[ib] == 0 && iss_b[ib+1] == 1, "R7 two-bank mapping", iss_b[ib]*10 + iss_b[ib+1], 1);

    // R10 lone client alternates
    set_cfg(2'd2, 4'd1);
    ib = iss_t.size();
    q_push(2, 32'h0); q_push(2, 32'h1);
    wait_idle();
    chk(iss_t[ib+1] - iss_t[ib] == 2, "R10 lone client spacing", iss_t[ib+1] - iss_t[ib], 2);

    // Random phases over modes and latencies
    for (int k = 0; k < 9; k++) begin
      set_cfg(2'(k % 3), 4'($urandom % 16));
      hold_cnt = 0;
      for (int s = 0; s < 400; s++) begin
        if ($urandom % 3 == 0) begin
          int r;
          r = int'($urandom % 3);
          if (q_size(r) < 3) q_push(r, $urandom);
        end
        if (!ext_want && $urandom % 80 == 0) ext_want = 1;
        step();
        if (ext_grant) hold_cnt++;
        if (hold_cnt >= 4) begin ext_want = 0; hold_cnt = 0; end
      end
      wait_idle();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule